// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes that an 8-bit controller with a multiplexed external bus presents to external memory. The first is an active-high address-latch pulse, which an external latch uses to capture the low address byte. The second is an active-low code-read strobe for external program memory. The oscillator clock drives the block directly. A phase counter divides each machine cycle into oscillator-period phases, and every strobe edge is tied to a fixed phase.

The core tells the block what kind of machine cycle comes next:
- whether it executes from external program memory;
- whether the cycle is an external data transfer;
- whether the running instruction is an external data move or a code-table read.

The core also supplies a configuration bit that disables the latch pulse. All four indications are captured once per machine cycle, at the cycle boundary. During a data transfer cycle the block drops the strobes that would collide with the transfer. With the disable bit set, the latch output stays low except during the qualifying instruction types, unless execution is external.

Top module: `strobe_gen`

## Requirements
- R1: A machine cycle lasts 12 clock periods, numbered phase 0 to 11. `ale` is high during phases 0-1 and phases 6-7 and low otherwise, which gives a pulse rate of one sixth of the clock.
- R2: `ext_exec`, `xdata_cyc`, `tbl_instr` and `ale_off` are sampled only on the clock edge that ends phase 11. They govern the whole of the following machine cycle, so a change at any other time has no effect until the next cycle starts.
- R3: In a cycle sampled with `xdata_cyc`=1, the first latch pulse (phases 0-1) is suppressed. The second pulse (phases 6-7) is kept.
- R4: In a cycle with `ext_exec`=1 and `xdata_cyc`=0, `psen_n` is low during phases 3-5 and 9-11 and high otherwise.
- R5: In a cycle with `ext_exec`=1 and `xdata_cyc`=1, both code-read activations are skipped and `psen_n` stays high.
- R6: In a cycle with `ext_exec`=0, `psen_n` stays high.
- R7: In a cycle with `ale_off`=1, `ext_exec`=0 and `tbl_instr`=0, `ale` stays low for the whole cycle.
- R8: In a cycle with `ale_off`=1 and `tbl_instr`=1, `ale` follows R1 and R3 as if `ale_off` were 0.
- R9: In a cycle with `ext_exec`=1, `ale_off` has no effect on `ale`.
- R10: While `rst` is high, `ale`=0 and `psen_n`=1, and all four sampled attributes read as 0. The first clock edge after `rst` falls starts phase 0 and samples the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_exec | input | 1 | Core fetches code from external program memory |
| xdata_cyc | input | 1 | Next machine cycle is an external data transfer |
| tbl_instr | input | 1 | Current instruction is an external data move or a code-table read |
| ale_off | input | 1 | Configuration bit that disables the free-running latch pulse |
| ale | output | 1 | Address latch pulse, active high, registered |
| psen_n | output | 1 | Code-read strobe, active low, registered |

## Verification
The embedded assertions check these properties on every cycle:
- the phase counter wraps correctly;
- each latch pulse lasts exactly two clocks;
- `psen_n` only falls at its two allowed phases and never falls during internal execution;
- no first-slot latch pulse appears in a data transfer cycle;
- the latch stays silent when disabled and not overridden.

The bench's behavioural reference model, compared on every clock, covers the rest:
- attributes change in the middle of a cycle without taking effect;
- every combination of the four attributes, including the override of the disable bit during external execution and by qualifying instructions;
- the exact phase alignment that follows release from reset.

// File: rtl/strb_pkg.sv
package strb_pkg;

  // Per-machine-cycle attributes captured at the cycle boundary.
  typedef struct packed {
    logic ext_exec;  // code comes from external program memory
    logic xdata;     // this cycle carries an external data transfer
    logic tbl;       // instruction is a data move or code-table read
    logic ale_off;   // free-running latch pulse disabled
  } cyc_attr_t;

  localparam cyc_attr_t ATTR_IDLE = '0;

endpackage

// File: rtl/strb_phase.sv
module strb_phase #(
  parameter int CYC_LEN = 12,
  parameter int PW      = $clog2(CYC_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] ph_q,
  output logic [PW-1:0] ph_d,
  output logic          wrap_d
);

  localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);

  always_comb begin
    wrap_d = (ph_q == LAST);
    ph_d   = wrap_d ? '0 : ph_q + 1'b1;
  end

  // Reset parks the counter on the last phase so the first edge starts phase 0.
  always_ff @(posedge clk) begin
    if (rst) ph_q <= LAST;
    else     ph_q <= ph_d;
  end

  a_r1_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (ph_q == LAST) |=> (ph_q == '0));

  a_r1_phase_range: assert property (@(posedge clk) disable iff (rst)
    (ph_q <= LAST));

endmodule

// File: rtl/strb_attr.sv
module strb_attr
  import strb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wrap_d,
  input  cyc_attr_t attr_in,
  output cyc_attr_t attr_q,
  output cyc_attr_t attr_d
);

  always_comb attr_d = wrap_d ? attr_in : attr_q;

  always_ff @(posedge clk) begin
    if (rst) attr_q <= ATTR_IDLE;
    else     attr_q <= attr_d;
  end

  // R2: the attributes stay frozen inside a machine cycle.
  a_r2_attr_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(wrap_d) |-> $stable(attr_q));

endmodule

// File: rtl/strb_window.sv
module strb_window #(
  parameter int PW    = 4,
  parameter int START = 0,
  parameter int WIDTH = 2
) (
  input  logic [PW-1:0] ph,
  output logic          hit
);

  localparam logic [PW:0] LO = (PW+1)'(START);
  localparam logic [PW:0] HI = (PW+1)'(START + WIDTH);

  generate
    if (START == 0) begin : g_from_zero
      assign hit = ({1'b0, ph} < HI);
    end else begin : g_offset
      assign hit = ({1'b0, ph} >= LO) && ({1'b0, ph} < HI);
    end
  endgenerate

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import strb_pkg::*;
#(
  parameter int CYC_LEN  = 12,
  parameter int NSLOT    = 2,
  parameter int ALE_W    = 2,
  parameter int PSEN_OFS = 3,
  parameter int PSEN_W   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_exec,
  input  logic xdata_cyc,
  input  logic tbl_instr,
  input  logic ale_off,
  output logic ale,
  output logic psen_n
);

  localparam int PW   = $clog2(CYC_LEN);
  localparam int SLOT = CYC_LEN / NSLOT;
  localparam logic [PW-1:0] ALE_W_PH = PW'(ALE_W);

  logic [PW-1:0] ph_q, ph_d;
  logic          wrap_d;
  cyc_attr_t     attr_in, attr_q, attr_d;

  assign attr_in = '{ext_exec: ext_exec, xdata: xdata_cyc,
                     tbl: tbl_instr, ale_off: ale_off};

  strb_phase #(.CYC_LEN(CYC_LEN), .PW(PW)) u_phase (
    .clk(clk), .rst(rst), .ph_q(ph_q), .ph_d(ph_d), .wrap_d(wrap_d)
  );

  strb_attr u_attr (
    .clk(clk), .rst(rst), .wrap_d(wrap_d),
    .attr_in(attr_in), .attr_q(attr_q), .attr_d(attr_d)
  );

  // One latch window and one code-read window per slot of the cycle.
  logic [NSLOT-1:0] ale_hit, psen_hit, ale_keep;

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      strb_window #(.PW(PW), .START(s*SLOT), .WIDTH(ALE_W)) u_ale_win (
        .ph(ph_d), .hit(ale_hit[s])
      );
      strb_window #(.PW(PW), .START(s*SLOT + PSEN_OFS), .WIDTH(PSEN_W)) u_psen_win (
        .ph(ph_d), .hit(psen_hit[s])
      );
      if (s == 0) begin : g_first
        // The first latch pulse collides with a data transfer.
        assign ale_keep[s] = !attr_d.xdata;
      end else begin : g_later
        assign ale_keep[s] = 1'b1;
      end
    end
  endgenerate

  logic ale_allow, ale_nx, psen_act_nx;

  always_comb begin
    ale_allow   = !attr_d.ale_off || attr_d.ext_exec || attr_d.tbl;
    ale_nx      = ale_allow && |(ale_hit & ale_keep);
    psen_act_nx = attr_d.ext_exec && !attr_d.xdata && |psen_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
    end else begin
      ale    <= ale_nx;
      psen_n <= !psen_act_nx;
    end
  end

  localparam logic [PW-1:0] PS_PH0 = PW'(PSEN_OFS);
  localparam logic [PW-1:0] PS_PH1 = PW'(SLOT + PSEN_OFS);

  a_r1_ale_width: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale ##1 !ale);

  a_r3_xdata_first_slot: assert property (@(posedge clk) disable iff (rst)
    (attr_q.xdata && ph_q < ALE_W_PH) |-> !ale);

  a_r4_psen_fall_phase: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |-> (ph_q == PS_PH0 || ph_q == PS_PH1));

  a_r5_xdata_no_psen: assert property (@(posedge clk) disable iff (rst)
    (attr_q.xdata) |-> psen_n);

  a_r6_internal_no_psen: assert property (@(posedge clk) disable iff (rst)
    (!attr_q.ext_exec) |-> psen_n);

  a_r7_ale_gated: assert property (@(posedge clk) disable iff (rst)
    (attr_q.ale_off && !attr_q.ext_exec && !attr_q.tbl) |-> !ale);

endmodule

// File: tb/strobe_gen_tb.sv
module strobe_gen_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_exec = 1'b0, xdata_cyc = 1'b0, tbl_instr = 1'b0, ale_off = 1'b0;
  logic ale, psen_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  strobe_gen u_dut (
    .clk(clk), .rst(rst), .ext_exec(ext_exec), .xdata_cyc(xdata_cyc),
    .tbl_instr(tbl_instr), .ale_off(ale_off), .ale(ale), .psen_n(psen_n)
  );

  // Behavioural reference: phase integer plus attributes captured at wrap.
  int m_ph;
  bit m_ext, m_xd, m_tbl, m_off;

  always @(posedge clk) begin
    if (rst) begin
      m_ph <= 11;
      m_ext <= 0; m_xd <= 0; m_tbl <= 0; m_off <= 0;
    end else if (m_ph == 11) begin
      m_ph <= 0;
      m_ext <= ext_exec; m_xd <= xdata_cyc; m_tbl <= tbl_instr; m_off <= ale_off;
    end else begin
      m_ph <= m_ph + 1;
    end
  end

  function automatic bit exp_ale();
    bit slot0 = (m_ph == 0 || m_ph == 1) && !m_xd;
    bit slot1 = (m_ph == 6 || m_ph == 7);
    return (slot0 || slot1) && (!m_off || m_ext || m_tbl);
  endfunction

  function automatic bit exp_psen_n();
    bit win = (m_ph >= 3 && m_ph <= 5) || (m_ph >= 9);
    return !(m_ext && !m_xd && win);
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s phase=%0d actual=%b expected=%b", tag, what, m_ph, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      string ta, tp;
      bit pending;
      pending = (m_ph != 11) &&
                ({ext_exec, xdata_cyc, tbl_instr, ale_off} != {m_ext, m_xd, m_tbl, m_off});
      if (rst)                          ta = "R10";
      else if (pending)                 ta = "R2";
      else if (m_off && m_ext)          ta = "R9";
      else if (m_off && m_tbl)          ta = "R8";
      else if (m_off)                   ta = "R7";
      else if (m_xd && m_ph < 2)        ta = "R3";
      else                              ta = "R1";
      if (rst)                          tp = "R10";
      else if (!m_ext)                  tp = "R6";
      else if (m_xd)                    tp = "R5";
      else                              tp = "R4";
      check(ta, ale, exp_ale(), "ale");
      check(tp, psen_n, exp_psen_n(), "psen_n");
    end
  end

  task automatic set_cfg(bit e, bit x, bit t, bit o, int clocks);
    @(negedge clk);
    ext_exec = e; xdata_cyc = x; tbl_instr = t; ale_off = o;
    repeat (clocks - 1) @(negedge clk);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: outputs idle during reset
    repeat (4) @(negedge clk);
    @(negedge clk);
    rst = 0;
    // R1 free-running, internal execution (R6)
    set_cfg(0, 0, 0, 0, 36);
    // R4 external execution
    set_cfg(1, 0, 0, 0, 36);
    // R3/R5 data transfer cycles
    set_cfg(1, 1, 0, 0, 24);
    set_cfg(0, 1, 0, 0, 24);
    // R7 disabled latch
    set_cfg(0, 0, 0, 1, 36);
    // R8 qualifying instruction
    set_cfg(0, 0, 1, 1, 24);
    set_cfg(0, 1, 1, 1, 24);
    // R9 external execution overrides disable
    set_cfg(1, 0, 0, 1, 24);
    set_cfg(1, 1, 0, 1, 24);
    // R2: changes at non-boundary times, all 16 combinations
    for (int k = 0; k < 400; k++) begin
      int v = (k * 7 + k / 16) % 16;
      set_cfg(v[3], v[2], v[1], v[0], 5 + (k % 9));
    end
    // R10: reset again mid-cycle, then resume
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    set_cfg(1, 0, 0, 0, 30);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule